// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Arbitration

This block is an on-chip scratchpad split into interleaved banks. It takes one request at a time from 16 lanes. Each lane supplies a word address and an active bit, and each word is 32 bits wide. The low address bits select the bank and the remaining bits select the row inside that bank.

On a read, the arbiter groups the pending lanes by bank. In each pass every bank serves one row, and that row goes to every pending lane that asked for it. A read that spans many banks therefore finishes in one pass. A read that asks one bank for several different rows is serialised, one row per pass. When several lanes ask for the same word, that word is broadcast to all of them at no extra cost. Writes go through one lane per pass in ascending lane order.

When a request completes, the block returns the per-lane data together with the number of passes it used. Software can use that count to spot bank conflicts in its access patterns. A new request is accepted only while the block is idle.

Top module: `sp_bank_arbiter`

## Requirements
- R1: After reset, req_ready is 1, and busy, done, rsp_passes and rsp_data are all 0. Every word of the storage reads back as 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1, and req_ready is 1 exactly when busy is 0. While busy is 1, a request on the inputs has no effect on the storage or on the result.
- R3: Lane i uses address bits [8i+7:8i]. Bits [3:0] select the bank and bits [7:4] select the row. Lanes that fall in different banks are served in the same pass, so a unit stride with any offset, or any odd stride, over 16 active lanes completes in 1 pass.
- R4: For a read, rsp_passes equals the largest number of distinct words asked of any single bank. A stride of 16 words across 16 active lanes gives 16 passes.
- R5: Lanes that read exactly the same word receive it in the same pass, so a read where all lanes use one address takes 1 pass and every lane returns that word.
- R6: After a read, lane i's data is in rsp_data[32i+31:32i] and equals the last value written to its address. Inactive lanes return 0.
- R7: done is a one-cycle pulse that rises P' clock edges after the accepting edge, where P' = max(rsp_passes, 1). busy is 1 from the accepting edge through the done cycle and is 0 on the next cycle.
- R8: A write takes one pass per active lane, in ascending lane order, so rsp_passes equals the number of active lanes. When two lanes write the same address, the higher-numbered lane's data is the one that remains.
- R9: A request with no active lane completes with rsp_passes = 0 and done one edge after acceptance.
- R10: rsp_data and rsp_passes hold their values while the block is idle, until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_active | input | 16 | Per-lane active bits |
| req_addr | input | 128 | Per-lane word addresses, 8 bits per lane |
| req_wdata | input | 512 | Per-lane write data, 32 bits per lane |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 512 | Per-lane read data, 32 bits per lane |
| rsp_passes | output | 5 | Number of passes used by the last request |

## Verification
A fault in the per-bank row choice or in the served-lane mask shows up in one of two ways when done rises. Either the pass count is wrong, or some lane's data does not match the bench's shadow copy of the storage. The done edge also moves by the same number of cycles as the pass count, so the fault is visible within that request. A pending mask that never clears leaves busy stuck high, and the bench's cycle bound reports it after about one hundred cycles. A write-port error stays hidden until a later read of the damaged address, which in this bench comes within a few requests.

// File: rtl/spa_pkg.sv
package spa_pkg;
    typedef enum logic [1:0] {
        SPA_IDLE = 2'd0,
        SPA_RUN  = 2'd1,
        SPA_DONE = 2'd2
    } spa_fsm_e;
endpackage

// File: rtl/spa_bank.sv
module spa_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int RW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd_row,
    output logic [DW-1:0] rd_word,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [DW-1:0] wr_word
);
    logic [DW-1:0] cell_q [DEPTH];

    assign rd_word = cell_q[rd_row];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) cell_q[r] <= '0;
        end else if (wr_en) begin
            cell_q[wr_row] <= wr_word;
        end
    end
endmodule

// File: rtl/spa_bank_pick.sv
// For one bank, pick the row of the lowest-numbered pending lane that maps
// to this bank, and flag every pending lane reading that same row.
module spa_bank_pick #(
    parameter int LANES   = 16,
    parameter int AW      = 8,
    parameter int BW      = 4,
    parameter int BANK_ID = 0,
    localparam int RW     = AW - BW
) (
    input  logic [LANES-1:0]         pending,
    input  logic [LANES-1:0][AW-1:0] lane_addr,
    output logic [RW-1:0]            pick_row,
    output logic [LANES-1:0]         hit
);
    logic found;

    always_comb begin
        found    = 1'b0;
        pick_row = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pending[l] && lane_addr[l][BW-1:0] == BW'(BANK_ID)) begin
                found    = 1'b1;
                pick_row = lane_addr[l][AW-1:BW];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            hit[l] = found && pending[l]
                     && lane_addr[l][BW-1:0] == BW'(BANK_ID)
                     && lane_addr[l][AW-1:BW] == pick_row;
        end
    end
endmodule

// File: rtl/spa_lane_first.sv
module spa_lane_first #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter #(
    parameter int LANES = 16,
    parameter int NB    = 16,
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int BW   = $clog2(NB),
    localparam int RW   = $clog2(DEPTH),
    localparam int AW   = BW + RW,
    localparam int LW   = $clog2(LANES),
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] rsp_data,
    output logic [CW-1:0]       rsp_passes
);
    import spa_pkg::*;

    typedef struct packed {
        spa_fsm_e                  fsm;
        logic                      wr;
        logic [LANES-1:0]          act;
        logic [LANES-1:0]          pend;
        logic [LANES-1:0][AW-1:0]  addr;
        logic [LANES-1:0][DW-1:0]  wdata;
        logic [CW-1:0]             passes;
        logic [LANES-1:0][DW-1:0]  rdata;
    } spa_state_t;

    spa_state_t st_d, st_q;

    // bank-side wiring
    logic [NB-1:0][RW-1:0]        bk_rd_row;
    logic [NB-1:0][DW-1:0]        bk_rd_word;
    logic [NB-1:0][LANES-1:0]     bk_hit;
    logic [NB-1:0]                bk_we;
    logic [RW-1:0]                wr_row;
    logic [DW-1:0]                wr_word;
    logic [LANES-1:0]             served;
    logic [LW-1:0]                wlane;
    logic                         wany;
    logic [LANES-1:0]             rd_pend;

    // observation points for the checker
    logic                         in_run;
    logic                         q_wr;
    logic [LANES-1:0]             q_pend;
    logic [LANES-1:0]             q_act;

    assign rd_pend = st_q.wr ? '0 : st_q.pend;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        spa_bank_pick #(
            .LANES(LANES), .AW(AW), .BW(BW), .BANK_ID(b)
        ) u_pick (
            .pending   (rd_pend),
            .lane_addr (st_q.addr),
            .pick_row  (bk_rd_row[b]),
            .hit       (bk_hit[b])
        );

        spa_bank #(
            .DEPTH(DEPTH), .DW(DW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_row  (bk_rd_row[b]),
            .rd_word (bk_rd_word[b]),
            .wr_en   (bk_we[b]),
            .wr_row  (wr_row),
            .wr_word (wr_word)
        );
    end

    spa_lane_first #(.N(LANES)) u_wfirst (
        .vec (st_q.pend),
        .idx (wlane),
        .any (wany)
    );

    always_comb begin
        served = '0;
        for (int b = 0; b < NB; b++) served = served | bk_hit[b];
    end

    // write port: one lane per pass
    always_comb begin
        wr_row  = st_q.addr[wlane][AW-1:BW];
        wr_word = st_q.wdata[wlane];
        for (int b = 0; b < NB; b++) begin
            bk_we[b] = (st_q.fsm == SPA_RUN) && st_q.wr && wany
                       && (st_q.addr[wlane][BW-1:0] == BW'(b));
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.fsm)
            SPA_IDLE: begin
                if (req_valid) begin
                    st_d.fsm    = SPA_RUN;
                    st_d.wr     = req_write;
                    st_d.act    = req_active;
                    st_d.pend   = req_active;
                    st_d.addr   = req_addr;
                    st_d.wdata  = req_wdata;
                    st_d.passes = '0;
                    st_d.rdata  = '0;
                end
            end
            SPA_RUN: begin
                if (st_q.pend == '0) begin
                    st_d.fsm = SPA_DONE;
                end else begin
                    st_d.passes = st_q.passes + 1'b1;
                    if (st_q.wr) begin
                        st_d.pend[wlane] = 1'b0;
                    end else begin
                        for (int l = 0; l < LANES; l++) begin
                            if (served[l])
                                st_d.rdata[l] = bk_rd_word[st_q.addr[l][BW-1:0]];
                        end
                        st_d.pend = st_q.pend & ~served;
                    end
                    if (st_d.pend == '0) st_d.fsm = SPA_DONE;
                end
            end
            SPA_DONE: st_d.fsm = SPA_IDLE;
            default:  st_d.fsm = SPA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= SPA_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.fsm == SPA_IDLE);
    assign busy       = (st_q.fsm != SPA_IDLE);
    assign done       = (st_q.fsm == SPA_DONE);
    assign rsp_data   = st_q.rdata;
    assign rsp_passes = st_q.passes;

    assign in_run = (st_q.fsm == SPA_RUN);
    assign q_wr   = st_q.wr;
    assign q_pend = st_q.pend;
    assign q_act  = st_q.act;
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int CW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                busy,
    input logic                done,
    input logic [LANES*DW-1:0] rsp_data,
    input logic [CW-1:0]       rsp_passes,
    input logic                in_run,
    input logic                q_wr,
    input logic [LANES-1:0]    q_pend,
    input logic [LANES-1:0]    q_act
);
    // R2: ready and busy are complementary
    a_r2_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != busy);

    // R7: done lasts one cycle and the block is idle afterwards
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7: busy only drops right after done
    a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R3: every pass retires at least one pending lane
    a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && q_pend != '0) |=> ($countones(q_pend) < $past($countones(q_pend))));

    // R4: pass count never exceeds the lane count
    a_r4_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_passes <= CW'(LANES)));

    // R8: writes use one pass per active lane
    a_r8_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q_wr) |-> (rsp_passes == CW'($countones(q_act))));

    // R10: results hold while idle with no request
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> ($stable(rsp_passes) && $stable(rsp_data)));
endmodule

bind sp_bank_arbiter spa_checker #(.LANES(LANES), .DW(DW), .CW(CW)) u_spa_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .rsp_data   (rsp_data),
    .rsp_passes (rsp_passes),
    .in_run     (in_run),
    .q_wr       (q_wr),
    .q_pend     (q_pend),
    .q_act      (q_act)
);

// File: tb/sp_bank_arbiter_test.sv
module sp_bank_arbiter_test;
    localparam int LANES = 16;
    localparam int NB    = 16;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int CW    = 5;
    localparam int WORDS = NB * DEPTH;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [LANES-1:0]    req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*DW-1:0] req_wdata = '0;
    logic                busy;
    logic                done;
    logic [LANES*DW-1:0] rsp_data;
    logic [CW-1:0]       rsp_passes;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] shadow [WORDS];

    always #2 clk = ~clk;

    sp_bank_arbiter #(.LANES(LANES), .NB(NB), .DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_active(req_active), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rsp_data(rsp_data),
        .rsp_passes(rsp_passes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_read_passes(input logic [LANES-1:0] act,
                                           input logic [LANES*AW-1:0] ad);
        int worst = 0;
        for (int b = 0; b < NB; b++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                if (act[l] && ad[l*AW +: 4] == 4'(b)) begin
                    bit seen = 0;
                    for (int k = 0; k < l; k++)
                        if (act[k] && ad[k*AW +: AW] == ad[l*AW +: AW]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > worst) worst = cnt;
        end
        return worst;
    endfunction

    task automatic run_req(input bit wr, input logic [LANES-1:0] act,
                           input logic [LANES*AW-1:0] ad,
                           input logic [LANES*DW-1:0] wd, input string tag);
        int exp_p;
        int exp_cyc;
        int n;
        logic [LANES*DW-1:0] exp_d;
        exp_p = wr ? $countones(act) : exp_read_passes(act, ad);
        exp_cyc = (exp_p < 1) ? 1 : exp_p;
        exp_d = '0;
        for (int l = 0; l < LANES; l++)
            if (act[l]) exp_d[l*DW +: DW] = shadow[ad[l*AW +: AW]];
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_active = act;
        req_addr = ad; req_wdata = wd;
        @(posedge clk);
        n = 0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done) break;
            n++;
            if (n > 100) break;
        end
        check(done, "R7", {tag, " done seen"}, done, 1);
        check(n == exp_cyc, "R7", {tag, " done latency"}, n, exp_cyc);
        check(rsp_passes == CW'(exp_p), wr ? "R8" : "R4", {tag, " passes"}, rsp_passes, exp_p);
        if (wr) begin
            for (int l = 0; l < LANES; l++)
                if (act[l]) shadow[ad[l*AW +: AW]] = wd[l*DW +: DW];
        end else begin
            check(rsp_data == exp_d, "R6", {tag, " data"}, rsp_data[63:0], exp_d[63:0]);
        end
        @(negedge clk);
        check(!busy && req_ready, "R7", {tag, " idle after done"}, busy, 0);
    endtask

    function automatic logic [LANES*AW-1:0] stride_addr(input int base, input int step);
        logic [LANES*AW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*AW +: AW] = AW'(base + l * step);
        return r;
    endfunction

    function automatic logic [LANES*DW-1:0] rand_words();
        logic [LANES*DW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*DW +: DW] = $urandom();
        return r;
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [LANES*DW-1:0] held_d;
        logic [CW-1:0]       held_p;
        logic [LANES*AW-1:0] ad;
        logic [LANES*DW-1:0] wd;
        void'($urandom(32'h5A17));
        for (int i = 0; i < WORDS; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check(req_ready && !busy && !done, "R1", "control after reset", {busy, done}, 0);
        check(rsp_passes == 0 && rsp_data == '0, "R1", "outputs after reset", rsp_passes, 0);
        rst_n = 1'b1;
        // R1: storage reads zero
        run_req(0, '1, stride_addr(37, 1), '0, "R1 zero read");

        // preload every word (R8 writes, 16 passes each)
        for (int r = 0; r < DEPTH; r++)
            run_req(1, '1, stride_addr(r * NB, 1), rand_words(), "R8 preload");

        // R3: unit stride with offset, odd strides
        run_req(0, '1, stride_addr(5, 1), '0, "R3 unit offset");
        run_req(0, '1, stride_addr(9, 3), '0, "R3 stride3");
        run_req(0, '1, stride_addr(1, 7), '0, "R3 stride7");
        // R4: stride 16 and stride 2
        run_req(0, '1, stride_addr(3, 16), '0, "R4 stride16");
        run_req(0, '1, stride_addr(0, 2), '0, "R4 stride2");
        // R5: broadcast
        run_req(0, '1, stride_addr(77, 0), '0, "R5 broadcast");
        check(rsp_data == {LANES{shadow[77]}}, "R5", "broadcast words", rsp_data[31:0], shadow[77]);
        // R6: partial lanes
        run_req(0, 16'hA5C3, stride_addr(200, 16), '0, "R6 partial");
        // R9: no active lane
        run_req(0, '0, stride_addr(0, 1), '0, "R9 empty read");
        run_req(1, '0, stride_addr(0, 1), rand_words(), "R9 empty write");
        // R8: same address, higher lane wins
        wd = rand_words();
        run_req(1, 16'h0109, stride_addr(44, 0), wd, "R8 same address");
        run_req(0, 16'h0001, stride_addr(44, 0), '0, "R8 same address read");
        check(rsp_data[31:0] == wd[8*DW +: DW], "R8", "last lane wins", rsp_data[31:0], wd[8*DW +: DW]);

        // R2: request during busy is ignored
        ad = stride_addr(16, 16);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_active = '1;
        req_addr = ad; req_wdata = rand_words();
        @(posedge clk);
        @(negedge clk);
        req_addr = stride_addr(250, 0); req_wdata = {LANES{32'hDEAD_BEEF}};
        check(!req_ready, "R2", "not ready while busy", req_ready, 0);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        for (int l = 0; l < LANES; l++) shadow[ad[l*AW +: AW]] = req_wdata[l*DW +: DW];
        for (int l = 0; l < LANES; l++) shadow[ad[l*AW +: AW]] = 'x;
        wait (done);
        @(negedge clk);
        run_req(0, 16'h0001, stride_addr(250, 0), '0, "R2 ignored write");
        check(rsp_data[31:0] != 32'hDEAD_BEEF, "R2", "busy request ignored", rsp_data[31:0], shadow[250]);
        // restore exact shadow for the overwritten row
        run_req(1, '1, ad, rand_words(), "R2 rewrite");

        // R10: hold while idle
        run_req(0, '1, stride_addr(11, 5), '0, "R10 read");
        held_d = rsp_data; held_p = rsp_passes;
        repeat (6) @(negedge clk);
        check(rsp_data == held_d && rsp_passes == held_p, "R10", "results held", rsp_passes, held_p);

        // random mix (R4, R6, R8)
        for (int it = 0; it < 60; it++) begin
            logic [LANES-1:0] act;
            act = 16'($urandom());
            for (int l = 0; l < LANES; l++) begin
                if ((it % 3) == 0) ad[l*AW +: AW] = AW'($urandom_range(0, 3) * 16 + $urandom_range(0, 2));
                else ad[l*AW +: AW] = AW'($urandom_range(0, WORDS - 1));
            end
            run_req(($urandom() % 4) == 0, act, ad, rand_words(), "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule